// File: doc/BRIEF.md
# Programmable Memory Bank Address Decoder

This block turns each CPU address into a choice of one external memory bank. It drives an active-low chip select for that bank and the byte offset of the access inside the bank. There are six ROM/SRAM/flash banks and four DRAM banks, each with its own window. The window is defined by two 10-bit page pointers at 64 KB granularity: a base pointer and a next pointer. There are also four external I/O banks that sit back to back, 16 KB apart, starting from one programmable base.

Software programs the pointers through a write-only register port. Each request is decoded in one cycle. On the following cycle the block presents the select, the offset, a cacheable flag and, if no window claimed the address, a decode-miss flag. Bit 26 of the address does not take part in the bank search. It only marks the access as non-cacheable. Address bits 31 to 27 are ignored.

Top module: `memBankDecoder`

## Requirements
- R1: A ROM or DRAM bank matches when address bits [25:16] are greater than or equal to its base pointer, so the first matching address is base pointer × 65536.
- R2: A ROM or DRAM window excludes the page named by its next pointer: next × 65536 − 1 is inside the window and next × 65536 is outside it.
- R3: A ROM or DRAM bank whose base pointer equals its next pointer, or exceeds it, never matches.
- R4: Every select is active-low. A request presented in cycle N gives rspValid high in cycle N+1 with at most one select low. In a cycle with no request, rspValid is low, every select is high and decodeMiss is low.
- R5: For a ROM or DRAM hit, bankOffset equals address[25:0] minus base × 65536. On a miss, bankOffset is zero.
- R6: I/O bank k covers ioBase × 65536 + k × 16384 through the 16383 bytes that follow it. bankOffset is the address within that 16 KB slot. When ioBase is zero, no I/O bank matches.
- R7: After reset, ROM bank 0 covers 0x0000000 to 0x1FFFFFF, and every other bank is unmapped.
- R8: Address bit 26, and bits 31 to 27, do not affect which bank matches. cacheable is the inverse of address bit 26.
- R9: When no window matches a request, all selects stay high and decodeMiss is high in the response cycle.
- R10: When windows overlap, the lowest-numbered ROM bank wins. If no ROM bank matches, the lowest-numbered DRAM bank wins. The I/O banks win only when no ROM or DRAM bank matches.
- R11: The register port writes cfgWrData at index cfgWrIdx. ROM bank b (b = 0 to 5) has its base at index 2b and its next pointer at 2b+1. DRAM bank d (d = 0 to 3) has its base at index 12+2d and its next pointer at 13+2d. The I/O base is at index 20. Writes to indexes 21 to 31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Pointer write strobe |
| cfgWrIdx | input | 5 | Pointer register index |
| cfgWrData | input | 10 | Pointer value, a 64 KB page number |
| reqValid | input | 1 | A request is present this cycle |
| reqAddr | input | 32 | Request byte address |
| rspValid | output | 1 | Response for the previous cycle's request |
| romSelN | output | 6 | ROM/SRAM/flash selects, active-low |
| dramSelN | output | 4 | DRAM selects, active-low |
| ioSelN | output | 4 | External I/O selects, active-low |
| bankOffset | output | 26 | Byte offset inside the selected bank |
| cacheable | output | 1 | Low when address bit 26 was set |
| decodeMiss | output | 1 | No window matched the request |

## Verification
A corrupted pointer register shows up on the very next request that lands near the affected window edge. The symptom is a wrong select, a miss where a hit was due, or an offset shifted by whole 64 KB pages. For that reason, the stimulus probes both sides of every programmed boundary. A fault in the priority choice or the response register shows up one cycle after the request, as two selects low together or as a select paired with decodeMiss. The assertions catch either case in that same cycle.

// File: rtl/memBankPkg.sv
package memBankPkg;
  localparam int NUM_ROM  = 6;
  localparam int NUM_DRAM = 4;
  localparam int NUM_IO   = 4;
  localparam int NUM_PAIR = NUM_ROM + NUM_DRAM;
  localparam int NUM_BANK = NUM_PAIR + NUM_IO;
  localparam int IDX_W    = 5;
  localparam int IO_IDX   = 2 * NUM_PAIR;

  typedef struct packed {
    logic [NUM_PAIR-1:0] wrBase;
    logic [NUM_PAIR-1:0] wrNext;
    logic                wrIo;
    logic                capture;
  } ctrlStrobe_t;
endpackage

// File: rtl/memBankCtrl.sv
module memBankCtrl
  import memBankPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [IDX_W-1:0] cfgWrIdx,
  input  logic             reqValid,
  output ctrlStrobe_t      strobe
);
  always_comb begin
    strobe.wrIo    = cfgWrEn && (cfgWrIdx == IDX_W'(IO_IDX));
    strobe.capture = reqValid;
  end

  for (genvar b = 0; b < NUM_PAIR; b++) begin : g_dec
    assign strobe.wrBase[b] = cfgWrEn && (cfgWrIdx == IDX_W'(2 * b));
    assign strobe.wrNext[b] = cfgWrEn && (cfgWrIdx == IDX_W'(2 * b + 1));
  end

  // R11
  unused_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrIdx > IDX_W'(IO_IDX)) |-> (strobe.wrBase == '0 && strobe.wrNext == '0 && !strobe.wrIo));
endmodule

// File: rtl/memBankDatapath.sv
module memBankDatapath
  import memBankPkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int PTR_W        = 10,
  parameter int PAGE_SHIFT   = 16,
  parameter int NC_BIT       = 26,
  parameter int IO_SLOT_LOG2 = 14,
  parameter logic [PTR_W-1:0] ROM0_NEXT_RST = 10'h200
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobe,
  input  logic [PTR_W-1:0]          wrData,
  input  logic [ADDR_W-1:0]         reqAddr,
  output logic                      rspValid,
  output logic [NUM_ROM-1:0]        romSelN,
  output logic [NUM_DRAM-1:0]       dramSelN,
  output logic [NUM_IO-1:0]         ioSelN,
  output logic [PTR_W+PAGE_SHIFT-1:0] bankOffset,
  output logic                      cacheable,
  output logic                      decodeMiss
);
  localparam int OFF_W    = PTR_W + PAGE_SHIFT;
  localparam int IO_SEL_W = (NUM_IO > 1) ? $clog2(NUM_IO) : 1;
  localparam logic [OFF_W-1:0] IO_SPAN = OFF_W'(NUM_IO) << IO_SLOT_LOG2;

  logic [PTR_W-1:0] basePtr [NUM_PAIR];
  logic [PTR_W-1:0] nextPtr [NUM_PAIR];
  logic [PTR_W-1:0] ioBase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PAIR; i++) begin
        basePtr[i] <= '0;
        nextPtr[i] <= (i == 0) ? ROM0_NEXT_RST : '0;
      end
      ioBase <= '0;
    end else begin
      for (int i = 0; i < NUM_PAIR; i++) begin
        if (strobe.wrBase[i]) basePtr[i] <= wrData;
        if (strobe.wrNext[i]) nextPtr[i] <= wrData;
      end
      if (strobe.wrIo) ioBase <= wrData;
    end
  end

  logic [PTR_W-1:0] reqPage;
  logic [OFF_W-1:0] reqLocal;
  assign reqPage  = reqAddr[OFF_W-1:PAGE_SHIFT];
  assign reqLocal = reqAddr[OFF_W-1:0];

  logic [NUM_BANK-1:0] hit;
  logic [OFF_W-1:0]    offArr [NUM_BANK];

  for (genvar i = 0; i < NUM_PAIR; i++) begin : g_pair
    assign hit[i]    = (reqPage >= basePtr[i]) && (reqPage < nextPtr[i]);
    assign offArr[i] = {reqPage - basePtr[i], reqAddr[PAGE_SHIFT-1:0]};
  end

  logic [OFF_W-1:0] ioStart, ioDiff;
  logic             ioInRange;
  assign ioStart   = {ioBase, {PAGE_SHIFT{1'b0}}};
  assign ioDiff    = reqLocal - ioStart;
  assign ioInRange = (ioBase != '0) && (reqLocal >= ioStart) && (ioDiff < IO_SPAN);

  for (genvar k = 0; k < NUM_IO; k++) begin : g_io
    assign hit[NUM_PAIR+k] = ioInRange && (ioDiff[IO_SLOT_LOG2 +: IO_SEL_W] == IO_SEL_W'(k));
    assign offArr[NUM_PAIR+k] = {{(OFF_W-IO_SLOT_LOG2){1'b0}}, ioDiff[IO_SLOT_LOG2-1:0]};
  end

  logic [NUM_BANK-1:0] grant;
  logic [OFF_W-1:0]    grantOff;
  always_comb begin
    grant    = '0;
    grantOff = '0;
    for (int i = NUM_BANK - 1; i >= 0; i--) begin
      if (hit[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        grantOff = offArr[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      romSelN    <= '1;
      dramSelN   <= '1;
      ioSelN     <= '1;
      bankOffset <= '0;
      cacheable  <= 1'b0;
      decodeMiss <= 1'b0;
    end else if (strobe.capture) begin
      rspValid   <= 1'b1;
      romSelN    <= ~grant[NUM_ROM-1:0];
      dramSelN   <= ~grant[NUM_PAIR-1:NUM_ROM];
      ioSelN     <= ~grant[NUM_BANK-1:NUM_PAIR];
      bankOffset <= grantOff;
      cacheable  <= ~reqAddr[NC_BIT];
      decodeMiss <= ~|hit;
    end else begin
      rspValid   <= 1'b0;
      romSelN    <= '1;
      dramSelN   <= '1;
      ioSelN     <= '1;
      bankOffset <= '0;
      cacheable  <= 1'b0;
      decodeMiss <= 1'b0;
    end
  end

  logic [NUM_BANK-1:0] allSelN;
  assign allSelN = {ioSelN, dramSelN, romSelN};

  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~allSelN));
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (&allSelN && !decodeMiss));
  // R4
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> rspValid);
  // R9
  miss_nosel_chk: assert property (@(posedge clk) disable iff (!rstN)
    decodeMiss |-> (&allSelN && bankOffset == '0));
  // R9
  hit_one_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !decodeMiss) |-> ($countones(~allSelN) == 1));
  // R6
  io_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !(&ioSelN)) |-> (bankOffset < (OFF_W'(1) << IO_SLOT_LOG2)));
  // R8
  cache_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (cacheable == !$past(reqAddr[NC_BIT])));
endmodule

// File: rtl/memBankDecoder.sv
module memBankDecoder
  import memBankPkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int PTR_W        = 10,
  parameter int PAGE_SHIFT   = 16,
  parameter int NC_BIT       = 26,
  parameter int IO_SLOT_LOG2 = 14
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWrEn,
  input  logic [IDX_W-1:0]            cfgWrIdx,
  input  logic [PTR_W-1:0]            cfgWrData,
  input  logic                        reqValid,
  input  logic [ADDR_W-1:0]           reqAddr,
  output logic                        rspValid,
  output logic [NUM_ROM-1:0]          romSelN,
  output logic [NUM_DRAM-1:0]         dramSelN,
  output logic [NUM_IO-1:0]           ioSelN,
  output logic [PTR_W+PAGE_SHIFT-1:0] bankOffset,
  output logic                        cacheable,
  output logic                        decodeMiss
);
  ctrlStrobe_t strobe;

  memBankCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx),
    .reqValid(reqValid), .strobe(strobe)
  );

  memBankDatapath #(
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .PAGE_SHIFT(PAGE_SHIFT),
    .NC_BIT(NC_BIT), .IO_SLOT_LOG2(IO_SLOT_LOG2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(cfgWrData),
    .reqAddr(reqAddr), .rspValid(rspValid), .romSelN(romSelN),
    .dramSelN(dramSelN), .ioSelN(ioSelN), .bankOffset(bankOffset),
    .cacheable(cacheable), .decodeMiss(decodeMiss)
  );
endmodule

// File: tb/memBankDecoder_bench.sv
module memBankDecoder_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [4:0]  cfgWrIdx = '0;
  logic [9:0]  cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        rspValid, cacheable, decodeMiss;
  logic [5:0]  romSelN;
  logic [3:0]  dramSelN, ioSelN;
  logic [25:0] bankOffset;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  memBankDecoder u_memBankDecoder (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx),
    .cfgWrData(cfgWrData), .reqValid(reqValid), .reqAddr(reqAddr),
    .rspValid(rspValid), .romSelN(romSelN), .dramSelN(dramSelN),
    .ioSelN(ioSelN), .bankOffset(bankOffset), .cacheable(cacheable),
    .decodeMiss(decodeMiss)
  );

  // {address, expected bank (0-5 ROM, 6-9 DRAM, 10-13 I/O, 14 miss), offset, cacheable}
  localparam int NV = 15;
  localparam logic [62:0] VEC [NV] = '{
    {32'h0000_0000, 4'd0,  26'h0000000, 1'b1},  // R1
    {32'h000F_FFFF, 4'd0,  26'h00FFFFF, 1'b1},  // R2
    {32'h0010_0000, 4'd1,  26'h0000000, 1'b1},  // R2
    {32'h0430_1234, 4'd3,  26'h0001234, 1'b0},  // R8 R10
    {32'h0038_0004, 4'd6,  26'h0180004, 1'b1},  // R5
    {32'h0050_0000, 4'd14, 26'h0000000, 1'b1},  // R3
    {32'h0060_0000, 4'd14, 26'h0000000, 1'b1},  // R3
    {32'h0100_FFFF, 4'd2,  26'h000FFFF, 1'b1},  // R5
    {32'h0200_0000, 4'd7,  26'h0000000, 1'b1},  // R1
    {32'h03F0_0000, 4'd10, 26'h0000000, 1'b1},  // R6
    {32'h03F0_4001, 4'd11, 26'h0000001, 1'b1},  // R6
    {32'h03F0_FFFF, 4'd13, 26'h0003FFF, 1'b1},  // R6
    {32'h03F1_0000, 4'd14, 26'h0000000, 1'b1},  // R6 R9
    {32'hF800_0010, 4'd0,  26'h0000010, 1'b1},  // R8
    {32'h0700_0000, 4'd14, 26'h0000000, 1'b0}   // R2 R9
  };

  task automatic check(string tag, logic [13:0] expSelN, logic expMiss, logic [25:0] expOff,
                       logic expCache, logic expValid);
    logic [13:0] actSelN;
    actSelN = {ioSelN, dramSelN, romSelN};
    checks++;
    if (rspValid !== expValid || actSelN !== expSelN || decodeMiss !== expMiss ||
        bankOffset !== expOff || (expValid && cacheable !== expCache)) begin
      errors++;
      $display("FAIL %s: valid=%b sel=%b miss=%b off=%h c=%b expected valid=%b sel=%b miss=%b off=%h c=%b",
               tag, rspValid, actSelN, decodeMiss, bankOffset, cacheable,
               expValid, expSelN, expMiss, expOff, expCache);
    end
  endtask

  task automatic request(string tag, logic [31:0] a, int bank, logic [25:0] off, logic c);
    logic [13:0] es;
    es = '1;
    if (bank < 14) es[bank] = 1'b0;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    @(posedge clk);
    #1;
    check(tag, es, bank == 14, off, c, 1'b1);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic wrReg(int idx, logic [9:0] d);
    @(negedge clk);
    cfgWrEn   = 1'b1;
    cfgWrIdx  = 5'(idx);
    cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R4 reset idle", 14'h3FFF, 1'b0, 26'h0, 1'b0, 1'b0);

    request("R7 rom0 top", 32'h01FF_FFFF, 0, 26'h1FF_FFFF, 1'b1);
    request("R7 beyond rom0", 32'h0200_0000, 14, 26'h0, 1'b1);
    request("R6 io off at zero base", 32'h0000_0000, 0, 26'h0, 1'b1);
    request("R7 R6 io unmapped", 32'h03F0_0000, 14, 26'h0, 1'b1);

    wrReg(31, 10'h000);
    wrReg(21, 10'h3F0);
    request("R11 ignored idx31", 32'h01FF_FFFF, 0, 26'h1FF_FFFF, 1'b1);
    request("R11 ignored idx21", 32'h03F0_0000, 14, 26'h0, 1'b1);

    wrReg(1, 10'h010);  wrReg(2, 10'h010);  wrReg(3, 10'h020);
    wrReg(4, 10'h100);  wrReg(5, 10'h101);  wrReg(6, 10'h030);
    wrReg(7, 10'h038);  wrReg(8, 10'h050);  wrReg(9, 10'h050);
    wrReg(10, 10'h060); wrReg(11, 10'h050); wrReg(12, 10'h020);
    wrReg(13, 10'h040); wrReg(14, 10'h200); wrReg(15, 10'h300);
    wrReg(20, 10'h3F0);

    for (int i = 0; i < NV; i++) begin
      request($sformatf("vector %0d", i), VEC[i][62:31], int'(VEC[i][30:27]),
              VEC[i][26:1], VEC[i][0]);
    end

    // R4: back-to-back requests, then a gap cycle
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = 32'h0010_0008;
    @(negedge clk);
    reqAddr  = 32'h0038_0000;
    check("R4 b2b first", 14'h3FFD, 1'b0, 26'h8, 1'b1, 1'b1);
    @(negedge clk);
    reqValid = 1'b0;
    check("R4 b2b second", 14'h3FBF, 1'b0, 26'h18_0000, 1'b1, 1'b1);
    @(negedge clk);
    check("R4 gap idle", 14'h3FFF, 1'b0, 26'h0, 1'b0, 1'b0);

    // R10: DRAM bank 3 over the I/O region wins
    wrReg(18, 10'h3F0);
    wrReg(19, 10'h3F1);
    request("R10 dram over io", 32'h03F0_4001, 9, 26'h4001, 1'b1);
    // R3: equal pointers on DRAM bank 3 remove it again
    wrReg(19, 10'h3F0);
    request("R3 dram3 disabled", 32'h03F0_4001, 11, 26'h1, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule